// File: doc/BRIEF.md
# L1 Coherence Request Responder

This block sits inside a first-level cache node that holds both a data cache and an instruction cache. It accepts coherence command flits from the memory side. Each flit is either a broadcast invalidate, which it recognises by the fixed address value 0x3, or a targeted command whose type is given by the four low address bits. It presents the line index to both caches through a combinational lookup port. It pulses the matching invalidate or update strobe, then returns zero, one or two single-flit responses, each tagged with the cache that produced it.

The same block formats cleanup flits toward the memory cache when a cache evicts a line on its own. The data cache and the instruction cache each raise a request. A fixed priority picks one, and the chosen flit carries the line address and a transaction ID that names the source cache. The caches themselves, update data movement and the network are outside this block.

Top module: `coh_responder`

## Requirements
- R1: After reset, cmdReady is 1, rspValid is 0 and all four cache strobes are 0.
- R2: A command with cmdAddr equal to 0x3 is a broadcast invalidate. Its line index is {cmdWdata[LINE_W-3:0], cmdBe[1:0]}. In the cycle after the command is accepted, this index is driven on lookupLine.
- R3: A broadcast pulses dInval for one cycle if dHit is 1 and iInval if iHit is 1, both in the cycle after acceptance. It returns one response for each hitting cache, with rspSrc 0 for data sent before rspSrc 1 for instruction. If neither cache hits, it returns no response.
- R4: For any other command, the line index is cmdAddr[LINE_W+3:4], and cmdAddr[3:0] selects the action. 4'b0000 pulses dInval, 4'b0100 pulses iInval, 4'b1000 pulses dUpdate and 4'b1100 pulses iUpdate. Each of these returns exactly one response, whether or not the line hits. The response has rspSrc 0 for the data codes and 1 for the instruction codes.
- R5: A command whose low bits match none of the codes in R4, and which is not a broadcast, pulses no strobe and returns no response. cmdReady returns to 1 two cycles after acceptance.
- R6: A response is held, with rspSrc unchanged, until rspReady is 1. While any response of a command is still unsent, cmdReady stays 0.
- R7: clnValid is 1 whenever dEvictReq or iEvictReq is 1. clnAddr is {line, 4'b0000} of the selected request, and clnTrdid is 0 for a data-cache cleanup and 1 for an instruction-cache cleanup.
- R8: When both caches request a cleanup, the data request is selected. dEvictAck or iEvictAck is 1 only in a cycle in which the selected request's flit is accepted (clnValid and clnReady).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Coherence command flit valid |
| cmdReady | output | 1 | Block can accept a command |
| cmdAddr | input | LINE_W+4 | Command address field |
| cmdWdata | input | DATA_W | Command write-data field |
| cmdBe | input | 4 | Command byte-enable field |
| lookupLine | output | LINE_W | Line index presented to both caches |
| dHit | input | 1 | Data cache holds lookupLine |
| iHit | input | 1 | Instruction cache holds lookupLine |
| dInval | output | 1 | Invalidate strobe to the data cache |
| iInval | output | 1 | Invalidate strobe to the instruction cache |
| dUpdate | output | 1 | Update strobe to the data cache |
| iUpdate | output | 1 | Update strobe to the instruction cache |
| rspValid | output | 1 | Response flit valid |
| rspReady | input | 1 | Response flit accepted |
| rspSrc | output | 1 | Responding cache: 0 data, 1 instruction |
| dEvictReq | input | 1 | Data cache cleanup request |
| dEvictLine | input | LINE_W | Line evicted by the data cache |
| iEvictReq | input | 1 | Instruction cache cleanup request |
| iEvictLine | input | LINE_W | Line evicted by the instruction cache |
| clnValid | output | 1 | Cleanup flit valid |
| clnReady | input | 1 | Cleanup flit accepted |
| clnAddr | output | LINE_W+4 | Cleanup line address |
| clnTrdid | output | 1 | Cleanup transaction ID: 0 data, 1 instruction |
| dEvictAck | output | 1 | Data cleanup flit taken |
| iEvictAck | output | 1 | Instruction cleanup flit taken |

## Verification
The bench targets a broadcast that hits both caches. A design that folded the two copies into one response, or sent the instruction response first, would show a wrong response count or order. A broadcast that misses everywhere, and a code outside the four defined values, both check that the block stays silent; a design that acknowledged every command would produce a spurious response. Stalling rspReady between the two responses of a double hit shows whether the second response is dropped, or whether a new command slips in early. Simultaneous cleanup requests expose a reversed priority or a transaction ID that does not follow the selected cache.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_BCAST, K_INV_D, K_INV_I, K_UPD_D, K_UPD_I
  } cohKind_t;

  typedef struct packed {
    logic capture;
    logic evaluate;
    logic retire;
  } ctlStrobe_t;
endpackage

// File: rtl/coh_dp.sv
module coh_dp import coh_pkg::*; #(
  parameter int LINE_W = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = LINE_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [3:0]        cmdBe,
  input  logic              dHit,
  input  logic              iHit,
  output logic [LINE_W-1:0] lookupLine,
  output logic              dInval,
  output logic              iInval,
  output logic              dUpdate,
  output logic              iUpdate,
  output logic              rspSrc,
  output logic              respNeeded,
  output logic              lastPend
);
  cohKind_t kindQ, kindD;
  logic [LINE_W-1:0] lineQ, lineD;
  logic pendD, pendI, newPendD, newPendI;
  logic isBcast;

  assign isBcast = (cmdAddr == ADDR_W'(3));

  always_comb begin
    kindD = K_NONE;
    if (isBcast) kindD = K_BCAST;
    else begin
      case (cmdAddr[3:0])
        4'b0000: kindD = K_INV_D;
        4'b0100: kindD = K_INV_I;
        4'b1000: kindD = K_UPD_D;
        4'b1100: kindD = K_UPD_I;
        default: kindD = K_NONE;
      endcase
    end
    lineD = isBcast ? {cmdWdata[LINE_W-3:0], cmdBe[1:0]} : cmdAddr[ADDR_W-1:4];
  end

  always_comb begin
    newPendD = (kindQ == K_BCAST) ? dHit : (kindQ == K_INV_D || kindQ == K_UPD_D);
    newPendI = (kindQ == K_BCAST) ? iHit : (kindQ == K_INV_I || kindQ == K_UPD_I);
  end

  assign respNeeded = newPendD | newPendI;
  assign lastPend   = pendD ^ pendI;
  assign rspSrc     = ~pendD;
  assign lookupLine = lineQ;

  assign dInval  = ctl.evaluate & ((kindQ == K_BCAST & dHit) | kindQ == K_INV_D);
  assign iInval  = ctl.evaluate & ((kindQ == K_BCAST & iHit) | kindQ == K_INV_I);
  assign dUpdate = ctl.evaluate & (kindQ == K_UPD_D);
  assign iUpdate = ctl.evaluate & (kindQ == K_UPD_I);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ <= K_NONE;
      lineQ <= '0;
      pendD <= 1'b0;
      pendI <= 1'b0;
    end else begin
      if (ctl.capture) begin
        kindQ <= kindD;
        lineQ <= lineD;
      end
      if (ctl.evaluate) begin
        pendD <= newPendD;
        pendI <= newPendI;
      end else if (ctl.retire) begin
        if (pendD) pendD <= 1'b0;
        else       pendI <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/coh_ctl.sv
module coh_ctl import coh_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic       rspReady,
  output logic       rspValid,
  input  logic       respNeeded,
  input  logic       lastPend,
  output ctlStrobe_t ctl
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_RESP} state_t;
  state_t state;

  assign cmdReady     = (state == S_IDLE);
  assign rspValid     = (state == S_RESP);
  assign ctl.capture  = cmdValid & cmdReady;
  assign ctl.evaluate = (state == S_LOOK);
  assign ctl.retire   = rspValid & rspReady;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else begin
      case (state)
        S_IDLE: if (ctl.capture) state <= S_LOOK;
        S_LOOK: state <= respNeeded ? S_RESP : S_IDLE;
        S_RESP: if (ctl.retire && lastPend) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_clean.sv
module coh_clean #(
  parameter int LINE_W = 8,
  localparam int ADDR_W = LINE_W + 4
) (
  input  logic              dEvictReq,
  input  logic [LINE_W-1:0] dEvictLine,
  input  logic              iEvictReq,
  input  logic [LINE_W-1:0] iEvictLine,
  output logic              clnValid,
  input  logic              clnReady,
  output logic [ADDR_W-1:0] clnAddr,
  output logic              clnTrdid,
  output logic              dEvictAck,
  output logic              iEvictAck
);
  logic pickInstr;
  assign pickInstr = ~dEvictReq;
  assign clnValid  = dEvictReq | iEvictReq;
  assign clnTrdid  = pickInstr;
  assign clnAddr   = {(pickInstr ? iEvictLine : dEvictLine), 4'b0000};
  assign dEvictAck = clnValid & clnReady & ~pickInstr;
  assign iEvictAck = clnValid & clnReady & pickInstr;
endmodule

// File: rtl/coh_responder.sv
module coh_responder import coh_pkg::*; #(
  parameter int LINE_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [LINE_W+3:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [3:0]        cmdBe,
  output logic [LINE_W-1:0] lookupLine,
  input  logic              dHit,
  input  logic              iHit,
  output logic              dInval,
  output logic              iInval,
  output logic              dUpdate,
  output logic              iUpdate,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspSrc,
  input  logic              dEvictReq,
  input  logic [LINE_W-1:0] dEvictLine,
  input  logic              iEvictReq,
  input  logic [LINE_W-1:0] iEvictLine,
  output logic              clnValid,
  input  logic              clnReady,
  output logic [LINE_W+3:0] clnAddr,
  output logic              clnTrdid,
  output logic              dEvictAck,
  output logic              iEvictAck
);
  ctlStrobe_t ctl;
  logic respNeeded, lastPend;

  coh_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .rspReady(rspReady), .rspValid(rspValid), .respNeeded(respNeeded),
    .lastPend(lastPend), .ctl(ctl)
  );

  coh_dp #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdBe(cmdBe), .dHit(dHit), .iHit(iHit), .lookupLine(lookupLine),
    .dInval(dInval), .iInval(iInval), .dUpdate(dUpdate), .iUpdate(iUpdate),
    .rspSrc(rspSrc), .respNeeded(respNeeded), .lastPend(lastPend)
  );

  coh_clean #(.LINE_W(LINE_W)) u_clean (
    .dEvictReq(dEvictReq), .dEvictLine(dEvictLine), .iEvictReq(iEvictReq),
    .iEvictLine(iEvictLine), .clnValid(clnValid), .clnReady(clnReady),
    .clnAddr(clnAddr), .clnTrdid(clnTrdid), .dEvictAck(dEvictAck),
    .iEvictAck(iEvictAck)
  );
endmodule

// File: rtl/coh_responder_chk.sv
module coh_responder_chk #(
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              cmdValid,
  input logic              dInval,
  input logic              iInval,
  input logic              dUpdate,
  input logic              iUpdate,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rspSrc,
  input logic              dEvictReq,
  input logic              iEvictReq,
  input logic              clnValid,
  input logic              clnReady,
  input logic              clnTrdid,
  input logic [LINE_W-1:0] dEvictLine,
  input logic [LINE_W+3:0] clnAddr,
  input logic              dEvictAck,
  input logic              iEvictAck
);
  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspSrc));
  // R6
  no_cmd_during_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !cmdReady);
  // R3
  strobe_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dInval || iInval || dUpdate || iUpdate) |-> $past(cmdValid && cmdReady));
  // R4
  one_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((dInval || iInval) && (dUpdate || iUpdate)));
  // R7
  cln_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    dEvictReq |-> clnValid && !clnTrdid && clnAddr[LINE_W+3:4] == dEvictLine);
  // R8
  cln_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dEvictAck, iEvictAck}) && ((dEvictAck || iEvictAck) == (clnValid && clnReady)));
  // R8
  cln_instr_chk: assert property (@(posedge clk) disable iff (!rstN)
    iEvictReq && !dEvictReq |-> clnTrdid && !dEvictAck);
endmodule

bind coh_responder coh_responder_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .cmdValid(cmdValid),
  .dInval(dInval), .iInval(iInval), .dUpdate(dUpdate), .iUpdate(iUpdate),
  .rspValid(rspValid), .rspReady(rspReady), .rspSrc(rspSrc),
  .dEvictReq(dEvictReq), .iEvictReq(iEvictReq), .clnValid(clnValid),
  .clnReady(clnReady), .clnTrdid(clnTrdid), .dEvictLine(dEvictLine),
  .clnAddr(clnAddr), .dEvictAck(dEvictAck), .iEvictAck(iEvictAck)
);

// File: tb/coh_responder_bench.sv
`timescale 1ns/1ps
module coh_responder_bench;
  localparam int LW = 8;
  localparam int DW = 32;

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdReady;
  logic [LW+3:0] cmdAddr = '0;
  logic [DW-1:0] cmdWdata = '0;
  logic [3:0] cmdBe = '0;
  logic [LW-1:0] lookupLine;
  logic dHit, iHit, dInval, iInval, dUpdate, iUpdate;
  logic rspValid, rspReady = 1, rspSrc;
  logic dEvictReq = 0, iEvictReq = 0, clnValid, clnReady = 0, clnTrdid;
  logic [LW-1:0] dEvictLine = '0, iEvictLine = '0;
  logic [LW+3:0] clnAddr;
  logic dEvictAck, iEvictAck;

  logic dHas = 0, iHas = 0;
  logic [LW-1:0] dLine = '0, iLine = '0;
  assign dHit = dHas && lookupLine == dLine;
  assign iHit = iHas && lookupLine == iLine;

  int checks = 0, errors = 0;
  int rspCnt, dInvCnt, iInvCnt, dUpdCnt, iUpdCnt;
  logic rspLog [0:3];
  logic [LW-1:0] strobeLine;

  always #5 clk = ~clk;

  coh_responder #(.LINE_W(LW), .DATA_W(DW)) u_coh_responder (.*);

  always @(posedge clk) begin
    if (rspValid && rspReady) begin
      if (rspCnt < 4) rspLog[rspCnt] = rspSrc;
      rspCnt = rspCnt + 1;
    end
    if (dInval)  dInvCnt = dInvCnt + 1;
    if (iInval)  iInvCnt = iInvCnt + 1;
    if (dUpdate) dUpdCnt = dUpdCnt + 1;
    if (iUpdate) iUpdCnt = iUpdCnt + 1;
    if (dInval || iInval || dUpdate || iUpdate) strobeLine = lookupLine;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    rspCnt = 0; dInvCnt = 0; iInvCnt = 0; dUpdCnt = 0; iUpdCnt = 0;
    strobeLine = '0; rspLog[0] = 0; rspLog[1] = 0;
  endtask

  task automatic sendCmd(logic [LW+3:0] a, logic [DW-1:0] w, logic [3:0] b);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdAddr = a; cmdWdata = w; cmdBe = b; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic testReset();
    check("R1 cmdReady", int'(cmdReady), 1);
    check("R1 rspValid", int'(rspValid), 0);
    check("R1 strobes", int'({dInval, iInval, dUpdate, iUpdate}), 0);
  endtask

  task automatic testBcastBoth();
    clearLog();
    dHas = 1; iHas = 1; dLine = 8'hA5; iLine = 8'hA5;
    sendCmd(12'h003, 32'h0000_0029, 4'b0001);
    repeat (5) @(negedge clk);
    check("R2 lookup line", int'(strobeLine), 'hA5);
    check("R3 two responses", rspCnt, 2);
    check("R3 first src data", int'(rspLog[0]), 0);
    check("R3 second src instr", int'(rspLog[1]), 1);
    check("R3 both invals", dInvCnt + iInvCnt, 2);
  endtask

  task automatic testBcastInstrOnly();
    clearLog();
    dHas = 0; iHas = 1; iLine = 8'h3C;
    sendCmd(12'h003, 32'h0000_000F, 4'b1100);
    repeat (5) @(negedge clk);
    check("R3 single response", rspCnt, 1);
    check("R3 src instr", int'(rspLog[0]), 1);
    check("R3 no data inval", dInvCnt, 0);
    check("R2 line from wdata be", int'(strobeLine), 'h3C);
  endtask

  task automatic testBcastMiss();
    clearLog();
    dHas = 1; iHas = 1; dLine = 8'h11; iLine = 8'h22;
    sendCmd(12'h003, 32'h0000_0010, 4'b0000);
    repeat (5) @(negedge clk);
    check("R3 miss no response", rspCnt, 0);
    check("R3 miss no strobe", dInvCnt + iInvCnt, 0);
  endtask

  task automatic testTargeted(logic [3:0] code, int expSrc, string name);
    clearLog();
    dHas = 0; iHas = 0;
    sendCmd({8'h5E, code}, 32'hFFFF_FFFF, 4'hF);
    repeat (5) @(negedge clk);
    check({"R4 ", name, " one response"}, rspCnt, 1);
    check({"R4 ", name, " src"}, int'(rspLog[0]), expSrc);
    check({"R4 ", name, " line"}, int'(strobeLine), 'h5E);
    case (code)
      4'b0000: check("R4 dInval", dInvCnt, 1);
      4'b0100: check("R4 iInval", iInvCnt, 1);
      4'b1000: check("R4 dUpdate", dUpdCnt, 1);
      default: check("R4 iUpdate", iUpdCnt, 1);
    endcase
    check({"R4 ", name, " total strobes"}, dInvCnt + iInvCnt + dUpdCnt + iUpdCnt, 1);
  endtask

  task automatic testUnknown();
    clearLog();
    sendCmd({8'h77, 4'b0010}, 32'h0, 4'h0);
    @(negedge clk);
    check("R5 ready again", int'(cmdReady), 1);
    repeat (3) @(negedge clk);
    check("R5 no response", rspCnt, 0);
    check("R5 no strobe", dInvCnt + iInvCnt + dUpdCnt + iUpdCnt, 0);
  endtask

  task automatic testBackpressure();
    clearLog();
    rspReady = 0;
    dHas = 1; iHas = 1; dLine = 8'h40; iLine = 8'h40;
    sendCmd(12'h003, 32'h0000_0010, 4'b0000);
    repeat (4) @(negedge clk);
    check("R6 held valid", int'(rspValid), 1);
    check("R6 held src data", int'(rspSrc), 0);
    check("R6 no accept", int'(cmdReady), 0);
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    repeat (2) @(negedge clk);
    check("R6 second held", int'(rspValid), 1);
    check("R6 second src", int'(rspSrc), 1);
    check("R6 still no accept", int'(cmdReady), 0);
    rspReady = 1;
    repeat (2) @(negedge clk);
    check("R6 total sent", rspCnt, 2);
    check("R6 ready after", int'(cmdReady), 1);
  endtask

  task automatic testCleanup();
    dEvictLine = 8'h12; iEvictLine = 8'h34;
    dEvictReq = 1; iEvictReq = 1; clnReady = 0;
    #1;
    check("R7 valid", int'(clnValid), 1);
    check("R8 data wins trdid", int'(clnTrdid), 0);
    check("R7 data addr", int'(clnAddr), 'h120);
    check("R8 no ack when stalled", int'({dEvictAck, iEvictAck}), 0);
    clnReady = 1; #1;
    check("R8 data ack", int'({dEvictAck, iEvictAck}), 2);
    dEvictReq = 0; #1;
    check("R7 instr trdid", int'(clnTrdid), 1);
    check("R7 instr addr", int'(clnAddr), 'h340);
    check("R8 instr ack", int'({dEvictAck, iEvictAck}), 1);
    iEvictReq = 0; #1;
    check("R7 idle", int'(clnValid), 0);
    clnReady = 0;
  endtask

  initial begin
    clearLog();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testBcastBoth();
    testBcastInstrOnly();
    testBcastMiss();
    testTargeted(4'b0000, 0, "inv data");
    testTargeted(4'b0100, 1, "inv instr");
    testTargeted(4'b1000, 0, "upd data");
    testTargeted(4'b1100, 1, "upd instr");
    testUnknown();
    testBackpressure();
    testCleanup();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule